// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Address Filtering

This block turns a start/stop framed serial line into bytes held in a small buffer. An external divider provides `baud_tick`, which pulses sixteen times per bit period. The receiver finds each falling start edge and confirms it by a majority vote taken at mid-bit. It then shifts in eight or nine data bits, least significant first, and samples the stop bit. Each finished word goes into a two-entry buffer, together with its ninth bit and a framing flag.

Software writes a four-bit control word and reads the head of the buffer. A one-cycle `data_rd` pulse drops the head entry. In nine-bit mode, address filtering can be turned on. A filtering receiver keeps only the words whose ninth bit is 1, which is how a multi-drop link marks address words. If a word completes while both buffer entries are occupied, the receiver latches an overrun. From then on it accepts nothing until software clears the continuous-receive enable.

The framing state machine has five states. `ST_IDLE` waits for a low line and moves to `ST_START` on the first tick that sees the line low. `ST_START` votes at mid-bit: a high vote is a rejected glitch and returns to `ST_IDLE`, and a low vote moves to `ST_DATA` at the end of the bit. `ST_DATA` moves to `ST_STOP` after the last data bit. `ST_STOP` votes on the stop bit: a high vote returns to `ST_IDLE`, and a low vote moves to `ST_RELEASE`. `ST_RELEASE` waits for the line to return high and then goes to `ST_IDLE`. Whenever reception is off, the machine is forced back to `ST_IDLE`.

Top module: `uarx_top`

## Requirements
- R1: After reset, `ctrl_q`, `rx_data`, `rx_ninth`, `err_frame`, `err_overrun` and `rx_irq` all read 0.
- R2: Control word bit positions are: bit0 port enable, bit1 nine-bit mode, bit2 continuous receive, bit3 address filter. With bits 0 and 2 set and bit 1 clear, an 8-bit frame is received LSB first, `rx_data` shows the word and `rx_irq` goes high.
- R3: With bit1 set, nine data bits are received. The ninth appears on `rx_ninth` without any parity check. In 8-bit mode `rx_ninth` reads 0.
- R4: With bits 1 and 3 both set, a frame whose ninth bit is 0 is discarded without any visible effect. A frame whose ninth bit is 1 is loaded.
- R5: With bit3 clear, every frame is loaded regardless of its ninth bit.
- R6: If bit0 or bit2 is clear, the line is ignored: no frame is loaded and `rx_irq` does not rise.
- R7: A stop bit sampled as 0 loads the word with its framing flag set. `err_frame` shows the flag of the head entry.
- R8: The buffer holds two words in arrival order. `data_rd` removes the head, and all head fields follow the new head. An empty buffer shows zeros and `rx_irq` low.
- R9: A frame accepted while both entries are full sets `err_overrun` and is dropped. Later frames are dropped while the flag is set. Writing the control word with bit2 still set does not clear the flag. Only a clear bit2 clears it.
- R10: A low pulse on the line that is shorter than half a bit fails the start vote and loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| rx_in | input | 1 | Serial line, idle high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word to write |
| data_rd | input | 1 | Pop the head entry of the buffer |
| ctrl_q | output | 4 | Control word readback |
| rx_data | output | 8 | Head entry data byte |
| rx_ninth | output | 1 | Head entry ninth bit |
| err_frame | output | 1 | Head entry framing flag |
| err_overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt, buffer not empty |

## Verification
The bench targets the third word that lands on a full buffer. A design that overwrote an entry instead of dropping the word would show the wrong byte after two reads. A design that cleared overrun on any control write would lose the flag too early. Other cases covered are filtered words with ninth bit 0, which a broken filter would load and so raise the interrupt, and a short start glitch, which an unvoted detector would turn into a spurious word. Per-entry framing flags are also checked: a design with one shared flag would report the error against the wrong word once the head is popped.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_RELEASE
    } rx_state_t;

    typedef struct packed {
        logic          ferr;
        logic          ninth;
        logic [DW-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/uarx_frame.sv
module uarx_frame
    import uarx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx,
    input  logic     run,
    input  logic     nine,
    output logic     done,
    output rx_word_t word
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW + 2);
    localparam logic [CW-1:0] C_SA   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] C_SB   = CW'(OSR / 2);
    localparam logic [CW-1:0] C_MID  = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

    rx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic          s_a, s_b;
    logic [DW:0]   sh;
    logic          vote, tick_mid, tick_end, last_bit;

    assign vote     = (s_a & s_b) | (s_a & rx) | (s_b & rx);
    assign tick_mid = tick && (cnt == C_MID);
    assign tick_end = tick && (cnt == C_LAST);
    assign last_bit = (bit_idx == (nine ? BW'(DW) : BW'(DW - 1)));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (tick && !rx) nxt = ST_START;
            ST_START:   if (tick_mid && vote) nxt = ST_IDLE;
                        else if (tick_end) nxt = ST_DATA;
            ST_DATA:    if (tick_end && last_bit) nxt = ST_STOP;
            ST_STOP:    if (tick_mid) nxt = vote ? ST_IDLE : ST_RELEASE;
            ST_RELEASE: if (rx) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        if (!run) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
            sh      <= '0;
            done    <= 1'b0;
            word    <= '0;
        end else begin
            done <= 1'b0;
            if (!run || state == ST_IDLE || state == ST_RELEASE) begin
                cnt     <= '0;
                bit_idx <= '0;
            end else if (tick) begin
                cnt <= tick_end ? '0 : cnt + CW'(1);
                if (cnt == C_SA) s_a <= rx;
                if (cnt == C_SB) s_b <= rx;
                if (state == ST_DATA && tick_mid) sh <= {vote, sh[DW:1]};
                if (state == ST_DATA && tick_end) bit_idx <= bit_idx + BW'(1);
                if (state == ST_STOP && tick_mid) begin
                    done       <= 1'b1;
                    word.ferr  <= ~vote;
                    word.ninth <= nine & sh[DW];
                    word.data  <= nine ? sh[DW-1:0] : sh[DW:1];
                end
            end
        end
    end
endmodule

// File: rtl/uarx_fifo.sv
module uarx_fifo
    import uarx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t wword,
    input  logic     pop,
    output logic     full,
    output logic     empty,
    output rx_word_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    rx_word_t      mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [NW-1:0] level;

    assign full  = (level == NW'(DEPTH));
    assign empty = (level == '0);
    assign head  = mem[rptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[i] <= '0;
            else if (push && wptr == PW'(i))     mem[i] <= wword;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
            if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
            if (push && !pop)      level <= level + NW'(1);
            else if (pop && !push) level <= level - NW'(1);
        end
    end
endmodule

// File: rtl/uarx_top.sv
module uarx_top
    import uarx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rx_in,
    input  logic          ctrl_we,
    input  logic [3:0]    ctrl_wdata,
    input  logic          data_rd,
    output logic [3:0]    ctrl_q,
    output logic [DW-1:0] rx_data,
    output logic          rx_ninth,
    output logic          err_frame,
    output logic          err_overrun,
    output logic          rx_irq
);
    logic     rx_meta, rx_sync;
    logic     run, done, accept, push, pop, full, empty;
    rx_word_t word, head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
        end else begin
            rx_meta <= rx_in;
            rx_sync <= rx_meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    assign run    = ctrl_q[0] & ctrl_q[2];
    assign accept = done && run && !(ctrl_q[1] && ctrl_q[3] && !word.ninth);
    assign push   = accept && !err_overrun && !full;
    assign pop    = data_rd && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            err_overrun <= 1'b0;
        else if (!ctrl_q[2])                   err_overrun <= 1'b0;
        else if (accept && full && !err_overrun) err_overrun <= 1'b1;
    end

    uarx_frame #(.OSR(OSR)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (baud_tick),
        .rx   (rx_sync),
        .run  (run),
        .nine (ctrl_q[1]),
        .done (done),
        .word (word)
    );

    uarx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .wword(word),
        .pop  (pop),
        .full (full),
        .empty(empty),
        .head (head)
    );

    assign rx_irq    = !empty;
    assign rx_data   = empty ? '0 : head.data;
    assign rx_ninth  = empty ? 1'b0 : head.ninth;
    assign err_frame = empty ? 1'b0 : head.ferr;
endmodule

// File: rtl/uarx_chk.sv
module uarx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ctrl_q,
    input logic       data_rd,
    input logic       rx_irq,
    input logic       err_overrun,
    input logic       fifo_full
);
    a_r9_clear_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[2] |=> !err_overrun);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun && ctrl_q[2] |=> err_overrun);

    a_r9_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(fifo_full));

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq && !data_rd |=> rx_irq);

    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q[0] && ctrl_q[2]) && !rx_irq |=> !rx_irq);
endmodule

bind uarx_top uarx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_q     (ctrl_q),
    .data_rd    (data_rd),
    .rx_irq     (rx_irq),
    .err_overrun(err_overrun),
    .fifo_full  (full)
);

// File: tb/uarx_top_bench.sv
module uarx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic       data_rd = 1'b0;
    logic [3:0] ctrl_q;
    logic [7:0] rx_data;
    logic       rx_ninth, err_frame, err_overrun, rx_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0] mctrl = '0;
    logic [7:0] md [2];
    logic       mb [2];
    logic       mf [2];
    int         mcnt = 0;
    logic       movr = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) tick <= ~tick;

    uarx_top u_uarx_top (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rx_in(rx),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .data_rd(data_rd),
        .ctrl_q(ctrl_q), .rx_data(rx_data), .rx_ninth(rx_ninth),
        .err_frame(err_frame), .err_overrun(err_overrun), .rx_irq(rx_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit frame_taken(logic [3:0] c, logic b9);
        if (!(c[0] && c[2])) return 1'b0;
        if (c[1] && c[3] && !b9) return 1'b0;
        return 1'b1;
    endfunction

    task automatic write_ctrl(logic [3:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
        mctrl = v;
        if (!v[2]) movr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(logic [8:0] d, logic stop_bit);
        int nb;
        nb = mctrl[1] ? 9 : 8;
        @(negedge clk);
        rx = 1'b0;
        repeat (32) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx = d[i];
            repeat (32) @(negedge clk);
        end
        rx = stop_bit;
        repeat (32) @(negedge clk);
        rx = 1'b1;
        repeat (64) @(negedge clk);
        if (frame_taken(mctrl, mctrl[1] & d[8]) && !movr) begin
            if (mcnt < 2) begin
                md[mcnt] = mctrl[1] ? d[7:0] : d[7:0];
                mb[mcnt] = mctrl[1] & d[8];
                mf[mcnt] = ~stop_bit;
                mcnt++;
            end else begin
                movr = 1'b1;
            end
        end
    endtask

    task automatic rd();
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        if (mcnt > 0) begin
            md[0] = md[1]; mb[0] = mb[1]; mf[0] = mf[1];
            mcnt--;
        end
        @(negedge clk);
    endtask

    task automatic check_head(string tag);
        chk({tag, " irq"},     rx_irq,      mcnt > 0);
        chk({tag, " data"},    rx_data,     mcnt > 0 ? md[0] : 8'h00);
        chk({tag, " ninth"},   rx_ninth,    mcnt > 0 ? mb[0] : 1'b0);
        chk({tag, " ferr"},    err_frame,   mcnt > 0 ? mf[0] : 1'b0);
        chk({tag, " overrun"}, err_overrun, movr);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", ctrl_q, 4'h0);
        check_head("R1");

        // R6 port or continuous enable off
        write_ctrl(4'b0001);
        send(9'h05A, 1'b1);
        check_head("R6 port only");
        write_ctrl(4'b0100);
        send(9'h05A, 1'b1);
        check_head("R6 cont only");
        chk("R6 irq low", rx_irq, 1'b0);

        // R2 8-bit reception
        write_ctrl(4'b0101);
        send(9'h0A5, 1'b1);
        chk("R2 data", rx_data, 8'hA5);
        check_head("R2");
        rd();
        check_head("R8 empty after read");

        // R10 glitch rejected
        @(negedge clk);
        rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (400) @(negedge clk);
        check_head("R10 glitch");
        send(9'h03C, 1'b1);
        check_head("R10 after glitch");
        rd();

        // R3 / R5 nine-bit, no filter
        write_ctrl(4'b0111);
        send(9'h1C3, 1'b1);
        chk("R3 ninth", rx_ninth, 1'b1);
        check_head("R3");
        send(9'h055, 1'b1);
        check_head("R5 second");
        rd();
        chk("R5 ninth zero loaded", rx_data, 8'h55);
        check_head("R5 head");
        rd();

        // R4 address filter
        write_ctrl(4'b1111);
        send(9'h0AA, 1'b1);
        chk("R4 discarded", rx_irq, 1'b0);
        check_head("R4 drop");
        send(9'h1BB, 1'b1);
        chk("R4 kept", rx_data, 8'hBB);
        check_head("R4 keep");
        rd();

        // R7 framing flag per entry
        write_ctrl(4'b0101);
        send(9'h011, 1'b0);
        chk("R7 ferr", err_frame, 1'b1);
        send(9'h022, 1'b1);
        check_head("R7 head keeps flag");
        rd();
        chk("R7 next clean", err_frame, 1'b0);
        check_head("R7 after read");
        rd();

        // R9 overrun
        send(9'h001, 1'b1);
        send(9'h002, 1'b1);
        send(9'h003, 1'b1);
        chk("R9 set", err_overrun, 1'b1);
        check_head("R9 full");
        write_ctrl(4'b0101);
        chk("R9 write keeps", err_overrun, 1'b1);
        rd();
        rd();
        check_head("R9 drained");
        send(9'h005, 1'b1);
        chk("R9 blocked", rx_irq, 1'b0);
        write_ctrl(4'b0001);
        chk("R9 cleared", err_overrun, 1'b0);
        write_ctrl(4'b0101);
        send(9'h006, 1'b1);
        chk("R9 resumes", rx_data, 8'h06);
        check_head("R9 resumed");
        rd();

        // R8 random mix
        for (int n = 0; n < 24; n++) begin
            logic [3:0] c;
            logic [8:0] d;
            logic       s;
            c = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) != 0) c[0] = 1'b1;
            if ($urandom_range(0, 3) != 0) c[2] = 1'b1;
            if (c != mctrl) write_ctrl(c);
            d = 9'($urandom_range(0, 511));
            s = ($urandom_range(0, 3) != 0);
            send(d, s);
            check_head("R8 random");
            if ($urandom_range(0, 1) == 1) begin
                rd();
                check_head("R8 random read");
            end
        end
        summary();
    end
endmodule